// File: doc/BRIEF.md
# Differential Space-Time Block Encoder (two antennas, QPSK)

This block is the baseband symbol source of a two-antenna transmitter that uses differential space-time block coding. An internal maximal-length shift register supplies the information bits. Every code block takes four of those bits. They are Gray-mapped onto two QPSK points, A and B. The block multiplies A and B into the previously sent symbol pair, so each new pair carries its information as a rotation of the old one. A receiver can then decode without a channel estimate and without carrier phase recovery.

Each symbol pair goes out over two symbol slots as an orthogonal code. Every slot presents four signed components: I and Q for antenna 1, and I and Q for antenna 2. A slot moves downstream on a valid/ready handshake. An enable input decides whether a further block follows the one that has just completed. After reset, the first block sent is a fixed reference pair. It carries no data and starts the recursion.

Top module: `diff_stcode_tx`

## Requirements
- R1: During reset and after reset, `out_valid` is 0 until `enable` is seen high. The first block after any reset is the reference pair s1=(1+j)·AMP, s2=0. Slot 0 of that block shows ant1=(AMP,AMP) and ant2=(0,0). Slot 1 shows ant1=(0,0) and ant2=(AMP,−AMP).
- R2: Bits come from a 9-stage Fibonacci shift register with polynomial x^9+x^5+1, loaded with PN_SEED on reset. Each step emits bit 8 of the register, then shifts left and inserts bit8 XOR bit4 at bit 0.
- R3: Each data block uses the next four register bits b0..b3, in the order they are emitted. (b0,b1) give A and (b2,b3) give B. A bit of 0 maps to +1 and a bit of 1 maps to −1, with the first bit of each pair on the real axis.
- R4: When the previous pair is (p1,p2), the next pair is s1=(A·p1 − B·conj(p2))/2 and s2=(A·p2 + B·conj(p1))/2.
- R5: Slot 0 sends ant1=s1 and ant2=s2. Slot 1 sends ant1=−conj(s2) and ant2=conj(s1). `out_slot` shows which slot is being presented, and the two slots always alternate 0 then 1.
- R6: Every component presented is −AMP, 0 or +AMP. Within one slot, the squared components sum to 2·AMP².
- R7: While `out_valid` is 1 and `ready` is 0, every output holds its value and no register bits are consumed.
- R8: A slot transfers on a clock edge where `out_valid` and `ready` are both 1. If `enable` is 0 at the edge where slot 1 transfers, `out_valid` falls. The next block, computed at that edge, is presented when `enable` returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| enable | input | 1 | Allows a block to start or follow |
| ready | input | 1 | Downstream accepts the presented slot |
| out_valid | output | 1 | A slot is presented |
| out_slot | output | 1 | 0 for the first slot of a block, 1 for the second |
| ant1_i | output | W | Antenna 1 in-phase component, signed |
| ant1_q | output | W | Antenna 1 quadrature component, signed |
| ant2_i | output | W | Antenna 2 in-phase component, signed |
| ant2_q | output | W | Antenna 2 quadrature component, signed |

## Verification
The bench builds the encoder with W=4, AMP=5 and a seed that differs from the default. A scale of 5 in a 4-bit field puts ±AMP close to the signed limits, so any slip in sign extension or scaling shows up directly. The non-default seed makes the expected bit sequence depend on the seed parameter actually reaching the register. A reference model follows the recursion through long streams under random ready and enable patterns. This exercises every one of the 24 reachable pair states, holds in both slots, and restarts through reset while a block is in flight.

// File: rtl/dstx_pkg.sv
`timescale 1ns/1ps
// dstx_pkg: shared types for the differential space-time encoder.
// Symbol components are small signed integers in {-1,0,1}. They are stored
// as CW-bit two's complement and widened to IW bits for arithmetic.
package dstx_pkg;
    localparam int CW = 3;              // stored component width
    localparam int IW = 6;              // arithmetic width
    localparam int BITS_PER_BLOCK = 4;  // information bits per code block
    localparam int NSYM = 2;            // QPSK points per block

    typedef struct packed {
        logic [CW-1:0] re;
        logic [CW-1:0] im;
    } cpx_t;

    // Sign-extend a stored component to arithmetic width.
    function automatic logic signed [IW-1:0] sx(input logic [CW-1:0] v);
        return {{(IW-CW){v[CW-1]}}, v};
    endfunction
endpackage

// File: rtl/dstx_pn_source.sv
`timescale 1ns/1ps
// dstx_pn_source: Fibonacci shift register that yields NB bits per advance.
// Assumes SEED is nonzero in its low LEN bits. bits[0] is the first bit emitted.
module dstx_pn_source #(
    parameter int LEN  = 9,
    parameter int TAP  = 5,
    parameter int SEED = 421,
    parameter int NB   = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          advance,
    output logic [NB-1:0] bits
);
    localparam logic [LEN-1:0] SEED_V = LEN'(SEED);

    logic [LEN-1:0] lfsr_q;
    logic [LEN-1:0] lfsr_n;

    // Unroll NB register steps, collecting each emitted bit.
    always_comb begin
        logic [LEN-1:0] tmp;
        tmp = lfsr_q;
        for (int k = 0; k < NB; k++) begin
            bits[k] = tmp[LEN-1];
            tmp = {tmp[LEN-2:0], tmp[LEN-1] ^ tmp[TAP-1]};
        end
        lfsr_n = tmp;
    end

    // Register state: seed on reset, move only when a block is consumed.
    always_ff @(posedge clk) begin
        if (!rst_n)
            lfsr_q <= SEED_V;
        else if (advance)
            lfsr_q <= lfsr_n;
    end

    AST_PN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_q != '0); // R2
    AST_PN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !advance |=> $stable(lfsr_q)); // R7
endmodule

// File: rtl/dstx_qpsk_map.sv
`timescale 1ns/1ps
// dstx_qpsk_map: Gray maps each dibit of a block onto a QPSK point (+-1,+-1).
// Bit 0 gives +1 and bit 1 gives -1. The lower bit of a dibit is the real part.
// Purely combinational.
module dstx_qpsk_map
    import dstx_pkg::*;
(
    input  logic [BITS_PER_BLOCK-1:0] bits,
    output cpx_t                      coef_a,
    output cpx_t                      coef_b
);
    localparam logic [CW-1:0] PLUS1  = CW'(1);
    localparam logic [CW-1:0] MINUS1 = '1;

    cpx_t sym [NSYM];

    // One identical mapper per QPSK point.
    for (genvar g = 0; g < NSYM; g++) begin : g_sym
        assign sym[g].re = bits[2*g]   ? MINUS1 : PLUS1;
        assign sym[g].im = bits[2*g+1] ? MINUS1 : PLUS1;
    end

    assign coef_a = sym[0];
    assign coef_b = sym[1];
endmodule

// File: rtl/dstx_diff_core.sv
`timescale 1ns/1ps
// dstx_diff_core: holds the symbol pair to be sent and, on load, replaces it
// with the differentially encoded successor. Assumes A and B are QPSK points
// with components +-1. The pair then always stays within {-1,0,1} per component,
// and the halving is exact.
module dstx_diff_core
    import dstx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  cpx_t coef_a,
    input  cpx_t coef_b,
    output cpx_t cur1,
    output cpx_t cur2
);
    logic signed [IW-1:0] ar, ai, br, bi;
    logic signed [IW-1:0] p1r, p1i, p2r, p2i;
    logic signed [IW-1:0] n1r, n1i, n2r, n2i;
    cpx_t nxt1, nxt2;

    // Widen all operands for the complex products.
    always_comb begin
        ar  = sx(coef_a.re);  ai  = sx(coef_a.im);
        br  = sx(coef_b.re);  bi  = sx(coef_b.im);
        p1r = sx(cur1.re);    p1i = sx(cur1.im);
        p2r = sx(cur2.re);    p2i = sx(cur2.im);
    end

    // Doubled successor: 2*s1 = A*p1 - B*conj(p2), 2*s2 = A*p2 + B*conj(p1).
    always_comb begin
        n1r = (ar*p1r - ai*p1i) - (br*p2r + bi*p2i);
        n1i = (ar*p1i + ai*p1r) - (bi*p2r - br*p2i);
        n2r = (ar*p2r - ai*p2i) + (br*p1r + bi*p1i);
        n2i = (ar*p2i + ai*p2r) + (bi*p1r - br*p1i);
    end

    // Exact halving back onto the stored grid.
    always_comb begin
        nxt1.re = CW'(n1r >>> 1);
        nxt1.im = CW'(n1i >>> 1);
        nxt2.re = CW'(n2r >>> 1);
        nxt2.im = CW'(n2i >>> 1);
    end

    // Pair register: reference (1+j, 0) on reset, successor on each load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur1 <= '{re: CW'(1), im: CW'(1)};
            cur2 <= '{re: '0, im: '0};
        end else if (load) begin
            cur1 <= nxt1;
            cur2 <= nxt2;
        end
    end

    function automatic logic on_grid(input logic [CW-1:0] v);
        return (sx(v) >= -1) && (sx(v) <= 1);
    endfunction

    AST_EVEN_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !(n1r[0] | n1i[0] | n2r[0] | n2i[0])); // R4
    AST_ON_GRID: assert property (@(posedge clk) disable iff (!rst_n)
        on_grid(cur1.re) && on_grid(cur1.im) && on_grid(cur2.re) && on_grid(cur2.im)); // R6
    AST_UNIT_ENERGY: assert property (@(posedge clk) disable iff (!rst_n)
        (p1r*p1r + p1i*p1i + p2r*p2r + p2i*p2i) == IW'(2)); // R6
    AST_PAIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(cur1) && $stable(cur2))); // R7
endmodule

// File: rtl/dstx_slot_former.sv
`timescale 1ns/1ps
// dstx_slot_former: arranges the current pair into the two-slot orthogonal code
// and scales each component by AMP. Assumes AMP fits within signed W bits.
// Combinational.
module dstx_slot_former
    import dstx_pkg::*;
#(
    parameter int W   = 8,
    parameter int AMP = 32
) (
    input  logic                slot,
    input  cpx_t                cur1,
    input  cpx_t                cur2,
    output logic signed [W-1:0] a1_i,
    output logic signed [W-1:0] a1_q,
    output logic signed [W-1:0] a2_i,
    output logic signed [W-1:0] a2_q
);
    localparam int NLANE = 4;

    logic signed [IW-1:0] lane_in  [NLANE];
    logic signed [W-1:0]  lane_out [NLANE];

    // Slot 0: (s1, s2). Slot 1: (-conj(s2), conj(s1)).
    always_comb begin
        if (!slot) begin
            lane_in[0] = sx(cur1.re);
            lane_in[1] = sx(cur1.im);
            lane_in[2] = sx(cur2.re);
            lane_in[3] = sx(cur2.im);
        end else begin
            lane_in[0] = -sx(cur2.re);
            lane_in[1] = sx(cur2.im);
            lane_in[2] = sx(cur1.re);
            lane_in[3] = -sx(cur1.im);
        end
    end

    // One identical scaler per output component.
    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        assign lane_out[g] = W'(int'(lane_in[g]) * AMP);
    end

    assign a1_i = lane_out[0];
    assign a1_q = lane_out[1];
    assign a2_i = lane_out[2];
    assign a2_q = lane_out[3];
endmodule

// File: rtl/diff_stcode_tx.sv
`timescale 1ns/1ps
// diff_stcode_tx: two-antenna differential space-time block encoder with QPSK.
// Presents one slot at a time on a valid/ready handshake. A block's bits are
// consumed at the edge where its second slot transfers. Assumes the downstream
// samples outputs only while out_valid is high.
module diff_stcode_tx
    import dstx_pkg::*;
#(
    parameter int W       = 8,
    parameter int AMP     = 32,
    parameter int PN_LEN  = 9,
    parameter int PN_TAP  = 5,
    parameter int PN_SEED = 421
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  logic                ready,
    output logic                out_valid,
    output logic                out_slot,
    output logic signed [W-1:0] ant1_i,
    output logic signed [W-1:0] ant1_q,
    output logic signed [W-1:0] ant2_i,
    output logic signed [W-1:0] ant2_q
);
    logic                      valid_q;
    logic                      slot_q;
    logic                      blk_done;
    logic [BITS_PER_BLOCK-1:0] pn_bits;
    cpx_t                      coef_a, coef_b, cur1, cur2;

    assign blk_done = valid_q & ready & slot_q;

    dstx_pn_source #(
        .LEN(PN_LEN), .TAP(PN_TAP), .SEED(PN_SEED), .NB(BITS_PER_BLOCK)
    ) u_pn (
        .clk(clk), .rst_n(rst_n), .advance(blk_done), .bits(pn_bits)
    );

    dstx_qpsk_map u_map (
        .bits(pn_bits), .coef_a(coef_a), .coef_b(coef_b)
    );

    dstx_diff_core u_core (
        .clk(clk), .rst_n(rst_n), .load(blk_done),
        .coef_a(coef_a), .coef_b(coef_b), .cur1(cur1), .cur2(cur2)
    );

    dstx_slot_former #(.W(W), .AMP(AMP)) u_form (
        .slot(slot_q), .cur1(cur1), .cur2(cur2),
        .a1_i(ant1_i), .a1_q(ant1_q), .a2_i(ant2_i), .a2_q(ant2_q)
    );

    // Slot sequencer: start on enable, step on handshake, stop after slot 1 if disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            slot_q  <= 1'b0;
        end else if (!valid_q) begin
            valid_q <= enable;
            slot_q  <= 1'b0;
        end else if (ready) begin
            if (!slot_q) begin
                slot_q <= 1'b1;
            end else begin
                slot_q  <= 1'b0;
                valid_q <= enable;
            end
        end
    end

    assign out_valid = valid_q;
    assign out_slot  = slot_q;

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !ready) |=> (out_valid && $stable(out_slot) && $stable(ant1_i)
            && $stable(ant1_q) && $stable(ant2_i) && $stable(ant2_q))); // R7
    AST_SLOT_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && ready && !out_slot) |=> (out_valid && out_slot)); // R5
    AST_ENABLE_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && ready && out_slot && !enable) |=> !out_valid); // R8
    AST_IDLE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> !out_slot); // R1
endmodule

// File: tb/sim_diff_stcode_tx.sv
`timescale 1ns/1ps
// Bench for diff_stcode_tx: behavioural reference model compared every cycle.
module sim_diff_stcode_tx;
    localparam int W    = 4;
    localparam int AMP  = 5;
    localparam int SEED = 243;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0;
    logic ready = 1'b0;
    logic out_valid, out_slot;
    logic signed [W-1:0] ant1_i, ant1_q, ant2_i, ant2_q;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    string phase = "R1";

    // reference model state
    int m_valid, m_slot, m_lfsr;
    int p1r, p1i, p2r, p2i;

    always #2.5 clk = ~clk;

    diff_stcode_tx #(.W(W), .AMP(AMP), .PN_LEN(9), .PN_TAP(5), .PN_SEED(SEED)) u0 (
        .clk(clk), .rst_n(rst_n), .enable(enable), .ready(ready),
        .out_valid(out_valid), .out_slot(out_slot),
        .ant1_i(ant1_i), .ant1_q(ant1_q), .ant2_i(ant2_i), .ant2_q(ant2_q)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_valid = 0; m_slot = 0; m_lfsr = SEED & 511;
        p1r = 1; p1i = 1; p2r = 0; p2i = 0;
    endtask

    // Next pair from four register bits (R2, R3, R4).
    task automatic model_next_block();
        int b[4];
        int ar, ai, br, bi, q1r, q1i, q2r, q2i;
        for (int k = 0; k < 4; k++) begin
            int fb;
            b[k] = (m_lfsr >> 8) & 1;
            fb = ((m_lfsr >> 8) ^ (m_lfsr >> 4)) & 1;
            m_lfsr = ((m_lfsr << 1) | fb) & 511;
        end
        ar = b[0] ? -1 : 1;  ai = b[1] ? -1 : 1;
        br = b[2] ? -1 : 1;  bi = b[3] ? -1 : 1;
        q1r = (ar*p1r - ai*p1i) - (br*p2r + bi*p2i);
        q1i = (ar*p1i + ai*p1r) - (bi*p2r - br*p2i);
        q2r = (ar*p2r - ai*p2i) + (br*p1r + bi*p1i);
        q2i = (ar*p2i + ai*p2r) + (bi*p1r - br*p1i);
        p1r = q1r / 2; p1i = q1i / 2; p2r = q2r / 2; p2i = q2i / 2;
    endtask

    task automatic model_step(input bit r, input bit e, input bit y);
        if (!r) begin
            model_reset();
        end else if (m_valid == 0) begin
            m_valid = e; m_slot = 0;
        end else if (y) begin
            if (m_slot == 0) begin
                m_slot = 1;
            end else begin
                model_next_block();
                m_slot = 0;
                m_valid = e;
            end
        end
    endtask

    task automatic check_outputs();
        int e1r, e1i, e2r, e2i, nrg;
        chk(phase, "out_valid", int'(out_valid), m_valid);
        if (m_valid != 0) begin
            if (m_slot == 0) begin
                e1r = p1r; e1i = p1i; e2r = p2r; e2i = p2i;
            end else begin
                e1r = -p2r; e1i = p2i; e2r = p1r; e2i = -p1i;
            end
            chk(phase, "out_slot (R5)", int'(out_slot), m_slot);
            chk(phase, "ant1_i (R4)", int'(ant1_i), e1r * AMP);
            chk(phase, "ant1_q (R4)", int'(ant1_q), e1i * AMP);
            chk(phase, "ant2_i (R5)", int'(ant2_i), e2r * AMP);
            chk(phase, "ant2_q (R5)", int'(ant2_q), e2i * AMP);
            // R6: grid and energy, from the outputs alone
            nrg = int'(ant1_i)*int'(ant1_i) + int'(ant1_q)*int'(ant1_q)
                + int'(ant2_i)*int'(ant2_i) + int'(ant2_q)*int'(ant2_q);
            chk("R6", "slot energy", nrg, 2 * AMP * AMP);
        end
    endtask

    task automatic cyc(input bit r, input bit e, input bit y);
        @(negedge clk);
        check_outputs();
        rst_n = r; enable = e; ready = y;
        model_step(r, e, y);
    endtask

    initial begin
        model_reset();
        // R1: reset state, then idle with enable low
        phase = "R1";
        repeat (3) cyc(1'b0, 1'b0, 1'b0);
        repeat (4) cyc(1'b1, 1'b0, 1'b1);
        // R1: reference block, then continuous stream covering R2 R3 R4 R5
        repeat (4) cyc(1'b1, 1'b1, 1'b1);
        phase = "R2_R3_R4";
        repeat (120) cyc(1'b1, 1'b1, 1'b1);
        // R7: holds with ready low in both slots; R8: handshake pacing
        phase = "R7_R8";
        for (int i = 0; i < 600; i++)
            cyc(1'b1, 1'b1, ($urandom % 3) != 0);
        phase = "R7";
        repeat (5) cyc(1'b1, 1'b1, 1'b0);
        cyc(1'b1, 1'b1, 1'b1);
        repeat (5) cyc(1'b1, 1'b1, 1'b0);
        // R8: enable toggling, blocks stop after slot 1 and resume in sequence
        phase = "R8";
        for (int i = 0; i < 800; i++)
            cyc(1'b1, ($urandom % 4) != 0, ($urandom % 4) != 0);
        repeat (6) cyc(1'b1, 1'b0, 1'b1);
        repeat (6) cyc(1'b1, 1'b1, 1'b1);
        // R1: reset mid-stream returns to the reference block
        phase = "R1";
        cyc(1'b1, 1'b1, 1'b0);
        repeat (2) cyc(1'b0, 1'b1, 1'b1);
        repeat (40) cyc(1'b1, 1'b1, 1'b1);
        @(negedge clk);
        check_outputs();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule